// File: doc/BRIEF.md
# Edge-Selectable Interrupt Status Unit

This block gathers single-bit event sources from a mixed-signal peripheral, for example a converter-finished pulse and a pen-contact level from a resistive panel. It turns selected transitions of those sources into sticky status bits and raises one active-high interrupt line while any status bit is set. Each source has its own rising-edge enable and its own falling-edge enable, so a level source can be armed for either direction.

Software reaches the block through a plain register read/write port. Reading the status address returns the latched events. Writing a mask to that same address clears the matching bits, and the clear keeps acting for as long as the written mask stays in place. Software must therefore follow a clear with a write of zero before those bits can latch again. Source inputs are asynchronous and pass through a two-flop synchronizer. Edges are detected against the previous synchronized value.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the rising-enable, falling-enable and status registers all read 0 and `irq_o` is low.
- R2: The rising-enable register is at address 0x5E and the falling-enable register is at 0x60. Each reads back the value last written, masked to the implemented sources: bit 11 (converter done) and bit 12 (pen contact), so the mask is 0x1800.
- R3: A 0-to-1 transition on an implemented source whose rising-enable bit is set makes the matching status bit (address 0x62) read 1 on the third rising clock edge after the input changes. It is still 0 after the second edge.
- R4: A 1-to-0 transition on an implemented source whose falling-enable bit is set sets the matching status bit with the same three-edge latency.
- R5: A transition whose direction is not enabled for that source leaves its status bit at 0.
- R6: `irq_o` is high exactly when at least one status bit is set.
- R7: Writing a mask to address 0x62 clears the status bits set in the mask on that clock edge. Status bits outside the mask keep their value.
- R8: While the last value written to 0x62 has a bit set, the matching status bit stays 0 even when enabled edges arrive. After 0 is written to 0x62, the bit latches again.
- R9: When a clear write to a bit falls in the same cycle as an enabled edge on that bit, the clear wins. An edge on a bit outside the written mask in that cycle still latches.
- R10: A set status bit stays set after its source returns to its former level, until it is cleared.
- R11: Unimplemented bits read as 0, and addresses other than the three registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 16 | Asynchronous event sources, one per bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq_o | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
Two functions can act in the same cycle: a clear write to the status address and the latching of a synchronized edge. The bench provokes this by changing a source and then timing a clear write so that it occupies exactly the cycle in which the edge reaches the status register, two edges after the input change. It judges the result on the port: the cleared bit must read 0. In the same situation, a clear mask that names only the other source must leave the new edge latched.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [DW-1:0] SRC_USED = 16'h1800,
  parameter logic [AW-1:0] A_RISE = 8'h5E,
  parameter logic [AW-1:0] A_FALL = 8'h60,
  parameter logic [AW-1:0] A_STAT = 8'h62
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_i,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_o
);

  logic [DW-1:0] sync_a, sync_b, prev;
  logic [DW-1:0] rise_en, fall_en, status, clr_q;
  logic [DW-1:0] evt, clr_now;
  logic          wr_rise, wr_fall, wr_stat;

  assign wr_rise = wr_en && addr == A_RISE;
  assign wr_fall = wr_en && addr == A_FALL;
  assign wr_stat = wr_en && addr == A_STAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev   <= '0;
    end else begin
      sync_a <= src_i & SRC_USED;
      sync_b <= sync_a;
      prev   <= sync_b;
    end
  end

  assign evt = ((sync_b & ~prev & rise_en) | (~sync_b & prev & fall_en)) & SRC_USED;
  assign clr_now = wr_stat ? wdata : clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      clr_q   <= '0;
      status  <= '0;
    end else begin
      if (wr_rise) rise_en <= wdata & SRC_USED;
      if (wr_fall) fall_en <= wdata & SRC_USED;
      if (wr_stat) clr_q <= wdata;
      status <= (status | evt) & ~clr_now & SRC_USED;
    end
  end

  always_comb begin
    case (addr)
      A_RISE:  rdata = rise_en;
      A_FALL:  rdata = fall_en;
      A_STAT:  rdata = status;
      default: rdata = '0;
    endcase
  end

  assign irq_o = |status;

endmodule

module edge_irq_ctrl_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] A_STAT = 8'h62
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] status,
  input logic [DW-1:0] clr_q,
  input logic [DW-1:0] rise_en,
  input logic [DW-1:0] fall_en,
  input logic          irq_o
);

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT) |=> (status & $past(wdata)) == '0); // R7

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == A_STAT) && clr_q == '0) |=> (status & $past(status)) == $past(status)); // R10

  AST_NO_UNARMED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status)) & ~($past(rise_en) | $past(fall_en))) == '0); // R5

  AST_HELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == A_STAT)) |=> (status & $past(clr_q)) == '0); // R8

  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((rise_en | fall_en) != '0)); // R6

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.AW(AW), .DW(DW), .A_STAT(A_STAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .status(status), .clr_q(clr_q), .rise_en(rise_en), .fall_en(fall_en),
  .irq_o(irq_o)
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  localparam logic [7:0] RISE = 8'h5E, FALL = 8'h60, STAT = 8'h62;
  localparam logic [15:0] ADC = 16'h0800, PEN = 16'h1000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq_o;
  logic [15:0] src_i = '0, wdata = '0, rdata;
  logic [7:0] addr = '0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  edge_irq_ctrl u_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step(1);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_stat(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(STAT, v);
    chk(req, v, exp);
    chk({req, " irq"}, {15'd0, irq_o}, {15'd0, exp != '0});
  endtask

  task automatic clear_all();
    wr(STAT, 16'hFFFF); wr(STAT, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(RISE, v); chk("R1 rise", v, 16'h0);
    rd(FALL, v); chk("R1 fall", v, 16'h0);
    chk_stat("R1 status", 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(RISE, 16'hFFFF); rd(RISE, v); chk("R2 R11 rise mask", v, 16'h1800);
    wr(FALL, 16'h1234); rd(FALL, v); chk("R2 R11 fall mask", v, 16'h1000);
    rd(8'h70, v); chk("R11 unmapped", v, 16'h0);
    wr(RISE, 16'h0); wr(FALL, 16'h0);
  endtask

  task automatic t_rise();
    wr(RISE, ADC);
    src_i[11] = 1'b1;
    step(2); chk_stat("R3 not yet", 16'h0);
    step(1); chk_stat("R3 R6 rise set", ADC);
    src_i[11] = 1'b0;
    step(4); chk_stat("R10 sticky", ADC);
    wr(STAT, ADC); wr(STAT, 16'h0);
    chk_stat("R7 cleared", 16'h0);
  endtask

  task automatic t_fall();
    wr(RISE, 16'h0);
    src_i[12] = 1'b1; step(4);
    chk_stat("R5 rise not armed", 16'h0);
    wr(STAT, PEN); wr(STAT, 16'h0); wr(FALL, PEN);
    src_i[12] = 1'b0; step(3);
    chk_stat("R4 fall set", PEN);
    wr(FALL, 16'h0);
    clear_all();
  endtask

  task automatic t_disabled();
    wr(RISE, PEN); wr(FALL, PEN);
    src_i[11] = 1'b1; step(4);
    src_i[11] = 1'b0; step(4);
    chk_stat("R5 other source", 16'h0);
    wr(RISE, 16'h0); wr(FALL, 16'h0);
  endtask

  task automatic t_hold();
    wr(RISE, ADC);
    wr(STAT, ADC);
    src_i[11] = 1'b1; step(4);
    chk_stat("R8 held clear", 16'h0);
    wr(STAT, 16'h0);
    src_i[11] = 1'b0; step(3);
    src_i[11] = 1'b1; step(3);
    chk_stat("R8 released", ADC);
    src_i[11] = 1'b0;
    wr(RISE, 16'h0); clear_all();
  endtask

  task automatic t_partial();
    wr(RISE, ADC | PEN);
    src_i[11] = 1'b1; src_i[12] = 1'b1; step(3);
    chk_stat("R3 both set", ADC | PEN);
    wr(STAT, ADC); wr(STAT, 16'h0);
    chk_stat("R7 partial", PEN);
    src_i = '0;
    wr(RISE, 16'h0); clear_all();
  endtask

  task automatic t_coincide();
    wr(RISE, ADC); step(3);
    src_i[11] = 1'b1; step(2);
    wr(STAT, ADC); wr(STAT, 16'h0);
    chk_stat("R9 clear wins", 16'h0);
    src_i[11] = 1'b0; step(3);
    src_i[11] = 1'b1; step(2);
    wr(STAT, PEN); wr(STAT, 16'h0);
    chk_stat("R9 other mask", ADC);
    src_i[11] = 1'b0;
    wr(RISE, 16'h0); clear_all();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_disabled();
    t_hold();
    t_partial();
    t_coincide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule